// File: doc/BRIEF.md
# Bit-Field Memory Access Controller

This block sits between a processor core and a word-organised local memory. The core sees memory as one linear space of bits. It asks to read or write a field of 1 to 32 bits that may start at any bit address. The controller does all of the alignment, masking and merging itself. A field that crosses a word boundary is split into a low part and a high part. The two words are then accessed in ascending address order.

A field write is posted. The core hands the write over in a single cycle and moves on, while the controller runs the read-modify-write cycles on each affected word. The one-entry queue holds that pending operation. The core is held off only when it presents another read or write before the queued one has finished. A field read returns the field right-justified, either zero-filled or sign-extended. Because reads wait behind the queued write, a read always sees the data that was just written. The memory side is a single word port with a valid/ready handshake. It accepts any number of wait cycles.

Top module: `fieldmem_ctrl`

## Requirements
- R1: After reset, req_ready is 1, mem_valid is 0 and rd_valid is 0.
- R2: A read returns the field right-justified in rd_data for exactly one cycle, flagged by rd_valid. With req_sext low, the bits at and above position req_len are 0.
- R3: With req_sext high and the field's top bit (bit req_len-1 of the result) equal to 1, every bit of rd_data above the field is 1.
- R4: When bit offset plus req_len exceeds 32, the controller accesses word W and then word W+1, in that order. A read combines the two parts.
- R5: A field write changes only the req_len bits that start at the addressed bit. Every other bit of memory keeps its value.
- R6: A write with req_len = 32 and bit offset 0 is a single word write with no memory read, and it is issued in the cycle after acceptance.
- R7: A request is accepted on a clock edge where req_valid and req_ready are both 1. A write is acknowledged at once. req_ready then stays 0 until every memory access of that operation has completed, and a request presented meanwhile is held.
- R8: A read issued right after a write to an overlapping field returns the newly written bits.
- R9: While mem_valid is 1 and mem_ready is 0, mem_valid, mem_addr, mem_write and mem_wdata stay unchanged. Any number of wait cycles is tolerated.
- R10: Bit addressing works as follows. req_addr[31:5] is the word address driven on mem_addr and req_addr[4:0] is the bit offset. Field bit k sits at memory word bit offset+k, where bit 0 is the LSB. req_len is binary with legal values 1 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a field request |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = field write, 0 = field read |
| req_addr | input | 32 | Bit address of the field's first bit |
| req_len | input | 6 | Field length, 1 to 32 |
| req_sext | input | 1 | Sign-extend a read result |
| req_wdata | input | 32 | Write field, right-justified |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | 32 | Right-justified read result |
| mem_valid | output | 1 | Word access request |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_write | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 27 | Word address |
| mem_wdata | output | 32 | Word write data |
| mem_rdata | input | 32 | Word read data, valid when mem_valid and mem_ready |

## Verification
The assertions watch several properties on every cycle:
- the port request stays stable while memory stalls;
- req_ready stays low whenever a word access is outstanding;
- no write ever appears during a read operation;
- a second-word access happens only for a straddling field;
- the full-word write goes out in the cycle after acceptance;
- an unextended result has no bits above the field.

Some behaviour can only be shown by the bench's scenarios against its bit-level memory model: the merged contents of memory after each write, the exact field and sign extension returned by reads, the ascending word order of straddling accesses, the count of reads in the full-word case, and read-after-write coherency with wait states.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD0  = 3'd1,
    ST_WR0  = 3'd2,
    ST_RD1  = 3'd3,
    ST_WR1  = 3'd4
  } fmc_state_e;
endpackage

// File: rtl/fmc_split.sv
// Builds the field mask and the shifted write data for the low and high word.
module fmc_split #(
  parameter int WORD_W = 32,
  localparam int OFF_W = $clog2(WORD_W),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] fmask,
  output logic [WORD_W-1:0] mask_lo,
  output logic [WORD_W-1:0] mask_hi,
  output logic [WORD_W-1:0] data_lo,
  output logic [WORD_W-1:0] data_hi,
  output logic              span2,
  output logic              full
);
  logic [2*WORD_W-1:0] m2;
  logic [2*WORD_W-1:0] d2;
  logic [LEN_W:0]      end_bit;

  always_comb begin
    if (len >= LEN_W'(WORD_W)) fmask = '1;
    else                       fmask = (WORD_W'(1) << len) - WORD_W'(1);
    m2      = {{WORD_W{1'b0}}, fmask} << off;
    d2      = {{WORD_W{1'b0}}, wdata & fmask} << off;
    mask_lo = m2[WORD_W-1:0];
    mask_hi = m2[2*WORD_W-1:WORD_W];
    data_lo = d2[WORD_W-1:0];
    data_hi = d2[2*WORD_W-1:WORD_W];
    end_bit = (LEN_W+1)'(off) + (LEN_W+1)'(len);
    span2   = end_bit > (LEN_W+1)'(WORD_W);
    full    = (off == '0) && (len == LEN_W'(WORD_W));
  end
endmodule

// File: rtl/fmc_extract.sv
// Right-justifies a field taken from one or two words, then zero-fills or sign-extends it.
module fmc_extract #(
  parameter int WORD_W = 32,
  localparam int OFF_W = $clog2(WORD_W),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  input  logic              sext,
  input  logic [WORD_W-1:0] fmask,
  output logic [WORD_W-1:0] result
);
  logic [2*WORD_W-1:0] cat;
  logic [WORD_W-1:0]   raw;
  logic [OFF_W-1:0]    top_idx;
  logic                top_bit;

  always_comb begin
    cat     = {hi_word, lo_word} >> off;
    raw     = cat[WORD_W-1:0] & fmask;
    top_idx = OFF_W'(len - LEN_W'(1));
    top_bit = raw[top_idx];
    result  = (sext && top_bit) ? (raw | ~fmask) : raw;
  end
endmodule

// File: rtl/fieldmem_ctrl.sv
module fieldmem_ctrl
  import fmc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32,
  localparam int OFF_W   = $clog2(WORD_W),
  localparam int LEN_W   = OFF_W + 1,
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_sext,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               rd_valid,
  output logic [WORD_W-1:0]  rd_data,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_write,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata
);
  // queued operation
  fmc_state_e          state_q, state_d;
  logic                q_write, q_write_d;
  logic                q_sext, q_sext_d;
  logic [WADDR_W-1:0]  q_waddr, q_waddr_d;
  logic [OFF_W-1:0]    q_off, q_off_d;
  logic [LEN_W-1:0]    q_len, q_len_d;
  logic [WORD_W-1:0]   q_wdata, q_wdata_d;
  logic [WORD_W-1:0]   lo_q, lo_d;
  logic [WORD_W-1:0]   wbuf_q, wbuf_d;
  logic                rdv_q, rdv_d;
  logic [WORD_W-1:0]   rdd_q, rdd_d;

  logic [WORD_W-1:0] fmask, mask_lo, mask_hi, data_lo, data_hi;
  logic              span2, full_q;
  logic [WORD_W-1:0] ext_lo, ext_res;
  logic              accept, hs, full_in, second;

  fmc_split #(.WORD_W(WORD_W)) i_split (
    .off(q_off), .len(q_len), .wdata(q_wdata),
    .fmask(fmask), .mask_lo(mask_lo), .mask_hi(mask_hi),
    .data_lo(data_lo), .data_hi(data_hi), .span2(span2), .full(full_q)
  );

  assign ext_lo = (state_q == ST_RD1) ? lo_q : mem_rdata;

  fmc_extract #(.WORD_W(WORD_W)) i_extract (
    .lo_word(ext_lo), .hi_word(mem_rdata), .off(q_off), .len(q_len),
    .sext(q_sext), .fmask(fmask), .result(ext_res)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hs        = mem_valid && mem_ready;
  assign full_in   = (req_addr[OFF_W-1:0] == '0) && (req_len == LEN_W'(WORD_W));
  assign second    = (state_q == ST_RD1) || (state_q == ST_WR1);

  assign mem_valid = (state_q != ST_IDLE);
  assign mem_write = (state_q == ST_WR0) || (state_q == ST_WR1);
  assign mem_addr  = second ? (q_waddr + WADDR_W'(1)) : q_waddr;
  assign mem_wdata = wbuf_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  // next state
  always_comb begin
    state_d   = state_q;
    q_write_d = q_write;
    q_sext_d  = q_sext;
    q_waddr_d = q_waddr;
    q_off_d   = q_off;
    q_len_d   = q_len;
    q_wdata_d = q_wdata;
    lo_d      = lo_q;
    wbuf_d    = wbuf_q;
    rdv_d     = 1'b0;
    rdd_d     = rdd_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          q_write_d = req_write;
          q_sext_d  = req_sext;
          q_waddr_d = req_addr[ADDR_W-1:OFF_W];
          q_off_d   = req_addr[OFF_W-1:0];
          q_len_d   = req_len;
          q_wdata_d = req_wdata;
          if (req_write && full_in) begin
            wbuf_d  = req_wdata;
            state_d = ST_WR0;
          end else begin
            state_d = ST_RD0;
          end
        end
      end
      ST_RD0: begin
        if (hs) begin
          if (q_write) begin
            wbuf_d  = (mem_rdata & ~mask_lo) | (data_lo & mask_lo);
            state_d = ST_WR0;
          end else if (span2) begin
            lo_d    = mem_rdata;
            state_d = ST_RD1;
          end else begin
            rdv_d   = 1'b1;
            rdd_d   = ext_res;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WR0: begin
        if (hs) state_d = span2 ? ST_RD1 : ST_IDLE;
      end
      ST_RD1: begin
        if (hs) begin
          if (q_write) begin
            wbuf_d  = (mem_rdata & ~mask_hi) | (data_hi & mask_hi);
            state_d = ST_WR1;
          end else begin
            rdv_d   = 1'b1;
            rdd_d   = ext_res;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WR1: begin
        if (hs) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      q_write <= 1'b0;
      q_sext  <= 1'b0;
      q_waddr <= '0;
      q_off   <= '0;
      q_len   <= LEN_W'(1);
      q_wdata <= '0;
      lo_q    <= '0;
      wbuf_q  <= '0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      state_q <= state_d;
      q_write <= q_write_d;
      q_sext  <= q_sext_d;
      q_waddr <= q_waddr_d;
      q_off   <= q_off_d;
      q_len   <= q_len_d;
      q_wdata <= q_wdata_d;
      lo_q    <= lo_d;
      wbuf_q  <= wbuf_d;
      rdv_q   <= rdv_d;
      rdd_q   <= rdd_d;
    end
  end

  // assertions
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                               && $stable(mem_wdata));

  assert_stall_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  assert_full_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && full_in |=> mem_valid && mem_write);

  assert_read_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !q_write |-> !mem_write);

  assert_second_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && second |-> span2 && !full_q);

  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !q_sext && (q_len < LEN_W'(WORD_W)) |-> ((rd_data >> q_len) == '0));
endmodule

// File: tb/test_fieldmem_ctrl.sv
module test_fieldmem_ctrl;
  localparam int PERIOD = 10;
  localparam int NVEC   = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_sext = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [5:0]  req_len = 6'd1;
  logic        req_ready, rd_valid, mem_valid, mem_ready, mem_write;
  logic [31:0] rd_data, mem_wdata, mem_rdata;
  logic [26:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] mem [16];
  logic [31:0] ref_mem [16];
  int wait_cfg = 0, wcnt = 0;
  int n_rd = 0, n_wr = 0, first_a = -1, last_a = -1;

  always #(PERIOD/2) clk = ~clk;

  fieldmem_ctrl i_fieldmem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_sext(req_sext), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] init_word(int k);
    return (32'h9E3779B9 * (k + 1)) ^ 32'h5A0FC3E1;
  endfunction

  // memory model with programmable wait states
  assign mem_ready = mem_valid && (wcnt >= wait_cfg);
  assign mem_rdata = mem[mem_addr[3:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) mem[k] <= init_word(k);
      wcnt <= 0;
    end else begin
      wcnt <= (mem_valid && !mem_ready) ? wcnt + 1 : 0;
      if (mem_valid && mem_ready) begin
        if (mem_write) begin
          mem[mem_addr[3:0]] <= mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          n_rd <= n_rd + 1;
        end
        if (first_a < 0) first_a <= int'(mem_addr);
        last_a <= int'(mem_addr);
      end
    end
  end

  // bit-level reference model (R10 addressing)
  function automatic logic [31:0] ref_rd(int unsigned a, int len, bit sx);
    logic [31:0] r = '0;
    for (int k = 0; k < len; k++) begin
      int unsigned b;
      b = a + k;
      r[k] = ref_mem[(b >> 5) & 15][b & 31];
    end
    if (sx && r[len-1]) for (int k = len; k < 32; k++) r[k] = 1'b1;
    return r;
  endfunction

  task automatic ref_wr(int unsigned a, int len, logic [31:0] d);
    for (int k = 0; k < len; k++) begin
      int unsigned b;
      b = a + k;
      ref_mem[(b >> 5) & 15][b & 31] = d[k];
    end
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(bit wr, logic [31:0] a, int len, bit sx, logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    req_len = 6'(len); req_sext = sx; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_result(output logic [31:0] r);
    while (!rd_valid) @(negedge clk);
    r = rd_data;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic clr_log();
    n_rd = 0; n_wr = 0; first_a = -1; last_a = -1;
  endtask

  task automatic cmp_mem(string req);
    for (int k = 0; k < 16; k++)
      chk(mem[k] === ref_mem[k], req, mem[k], ref_mem[k]);
  endtask

  // vector: {wr, sext, waits[1:0], len[5:0], addr[31:0], data[31:0]}
  localparam logic [73:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'd0, 6'd8,  32'd5,   32'h000000A5},  // R5 R10 in-word write
    {1'b0, 1'b0, 2'd0, 6'd8,  32'd5,   32'h0},         // R2 read back
    {1'b1, 1'b0, 2'd2, 6'd12, 32'd60,  32'h00000F3C},  // R4 R5 straddling write
    {1'b0, 1'b1, 2'd0, 6'd12, 32'd60,  32'h0},         // R3 R4 sign-extended
    {1'b0, 1'b0, 2'd1, 6'd12, 32'd60,  32'h0},         // R2 zero-filled
    {1'b1, 1'b0, 2'd0, 6'd32, 32'd96,  32'hDEADBEEF},  // R6 full word
    {1'b0, 1'b0, 2'd3, 6'd32, 32'd100, 32'h0},         // R4 R9 straddle read, waits
    {1'b1, 1'b0, 2'd0, 6'd1,  32'd130, 32'h00000001},  // R5 single bit
    {1'b0, 1'b1, 2'd0, 6'd1,  32'd130, 32'h0},         // R3 one-bit sign-extend
    {1'b1, 1'b0, 2'd1, 6'd32, 32'd200, 32'h12345678},  // R4 R5 full length, offset 8
    {1'b0, 1'b0, 2'd0, 6'd32, 32'd200, 32'h0},         // R2 R4
    {1'b0, 1'b0, 2'd1, 6'd2,  32'd31,  32'h0}          // R4 two bits across words
  };

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, e;
    for (int k = 0; k < 16; k++) ref_mem[k] = init_word(k);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(mem_valid === 1'b0, "R1 mem_valid", 32'(mem_valid), 32'd0);
    chk(rd_valid === 1'b0, "R1 rd_valid", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [73:0] v;
      v = VEC[i];
      wait_cfg = int'(v[71:70]);
      if (v[73]) begin
        issue(1'b1, v[63:32], int'(v[69:64]), 1'b0, v[31:0]);
        ref_wr(v[63:32], int'(v[69:64]), v[31:0]);
        wait_idle();
        cmp_mem("R5 memory after write");
      end else begin
        e = ref_rd(v[63:32], int'(v[69:64]), v[72]);
        issue(1'b0, v[63:32], int'(v[69:64]), v[72], 32'h0);
        wait_result(r);
        chk(r === e, v[72] ? "R3 read sign-extended" : "R2 read field", r, e);
        wait_idle();
      end
    end

    // R6: full-word write issues one write, no read
    wait_cfg = 0;
    clr_log();
    issue(1'b1, 32'd256, 32, 1'b0, 32'hCAFEF00D);
    ref_wr(32'd256, 32, 32'hCAFEF00D);
    wait_idle();
    chk(n_rd == 0, "R6 reads", 32'(n_rd), 32'd0);
    chk(n_wr == 1, "R6 writes", 32'(n_wr), 32'd1);
    chk(mem[8] === 32'hCAFEF00D, "R6 word", mem[8], 32'hCAFEF00D);

    // R4: straddling write, ascending word order, two RMW pairs
    clr_log();
    issue(1'b1, 32'd312, 16, 1'b0, 32'h0000B00F);
    ref_wr(32'd312, 16, 32'h0000B00F);
    wait_idle();
    chk(first_a == 9, "R4 first word", 32'(first_a), 32'd9);
    chk(last_a == 10, "R4 last word", 32'(last_a), 32'd10);
    chk(n_rd == 2 && n_wr == 2, "R4 access count", 32'(n_rd * 16 + n_wr), 32'h22);
    cmp_mem("R5 straddle write");

    // R7/R8: posted write, then overlapping read held behind it
    wait_cfg = 2;
    issue(1'b1, 32'd380, 10, 1'b0, 32'h0000036A);
    ref_wr(32'd380, 10, 32'h0000036A);
    chk(req_ready === 1'b0, "R7 busy after posted write", 32'(req_ready), 32'd0);
    chk(mem[11] === init_word(11), "R7 write posted, memory not yet touched",
        mem[11], init_word(11));
    e = ref_rd(32'd384, 4, 1'b0);
    issue(1'b0, 32'd384, 4, 1'b0, 32'h0);
    wait_result(r);
    chk(r === e, "R8 read after write", r, e);
    wait_idle();
    cmp_mem("R7 memory after queued write");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule